// File: doc/BRIEF.md
# Program Counter Branch Target Calculator

This block produces the next 16-bit program counter value for the unconditional jump, subroutine call and relative branch forms of an 8-bit controller core. The decode stage presents the address of the next sequential instruction, the immediate bytes of the current instruction, the three address bits carried in the opcode, the accumulator and the 16-bit data pointer. It also presents a two-bit mode that selects how the target is formed.

Four target forms are supported:

- **Signed relative:** an 8-bit two's-complement offset is added to the next-instruction address.
- **Page-absolute:** an 11-bit in-page address replaces the low bits of the next-instruction address, so the target stays within the current 2 KB page.
- **Long:** a full 16-bit immediate target.
- **Indirect:** the data pointer plus the unsigned accumulator.

Alongside the target, the block returns the 16-bit return address that call forms push. Both results are registered, so they are available one clock after the inputs are presented. Stack handling and instruction fetch sit outside this block.

Top module: `pc_target_calc`

## Requirements
- R1: While rst_ni is low, target_o and ret_addr_o are both 16'h0000.
- R2: Each output is registered. After a rising clock edge it shows the result for the inputs sampled at that edge, and it holds that value until the next edge whatever the inputs do in between.
- R3: With mode_i = 2'b00 (relative), target_o = next_pc_i + sign-extended imm_lo_i, taken modulo 2^16, so results wrap in both directions.
- R4: With mode_i = 2'b01 (page-absolute), target_o[15:11] = next_pc_i[15:11], target_o[10:8] = page_bits_i, and target_o[7:0] = imm_lo_i. Here page_bits_i carries bits 7:5 of the first instruction byte.
- R5: With mode_i = 2'b10 (long), target_o = {imm_hi_i, imm_lo_i}, with imm_hi_i as the upper byte.
- R6: With mode_i = 2'b11 (indirect), target_o = dptr_i + {8'h00, acc_i}, taken modulo 2^16.
- R7: In every mode, ret_addr_o equals next_pc_i sampled at the same edge.
- R8: Inputs that the selected mode does not use have no effect on target_o. In long mode, next_pc_i, acc_i and dptr_i are ignored. In indirect mode, the immediate bytes and next_pc_i are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 2 | Target form: 00 relative, 01 page-absolute, 10 long, 11 indirect |
| next_pc_i | input | 16 | Address of the first byte of the following instruction |
| imm_lo_i | input | 8 | Relative offset, low address byte or long target low byte |
| imm_hi_i | input | 8 | Long target high byte |
| page_bits_i | input | 3 | Upper three address bits taken from the opcode byte |
| acc_i | input | 8 | Accumulator |
| dptr_i | input | 16 | Data pointer |
| target_o | output | 16 | Registered branch target |
| ret_addr_o | output | 16 | Registered return address for calls |

## Verification
The bench targets relative offsets that carry past 16'hFFFF and borrow below 16'h0000. A design that zero-extends the offset would jump forward instead of backward, and one with a wider sum would not wrap.

Page-absolute cases sit at the very top and bottom of a 2 KB page. A design that takes the page from the wrong source, or places the opcode bits in the wrong position, would leave the page or land at the wrong in-page address.

Indirect cases push dptr_i + acc_i past 16'hFFFF; sign-extending the accumulator would subtract instead. Unused operands are toggled in long and indirect modes, and inputs are changed between edges, to catch leakage from one mode into another and outputs that are not registered.

// File: rtl/pc_target_pkg.sv
package pc_target_pkg;
  localparam int unsigned PC_W   = 16;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned PAGE_W = 11;

  typedef enum logic [1:0] {
    TGT_REL  = 2'b00,
    TGT_PAGE = 2'b01,
    TGT_LONG = 2'b10,
    TGT_IND  = 2'b11
  } tgt_mode_e;
endpackage

// File: rtl/pcb_rel_adder.sv
module pcb_rel_adder #(
  parameter int unsigned PC_W  = 16,
  parameter int unsigned OFS_W = 8
) (
  input  logic [PC_W-1:0]  base_i,
  input  logic [OFS_W-1:0] ofs_i,
  output logic [PC_W-1:0]  sum_o
);
  localparam int unsigned EXT_W = PC_W - OFS_W;

  logic [PC_W-1:0] ofs_ext;

  assign ofs_ext = {{EXT_W{ofs_i[OFS_W-1]}}, ofs_i};
  assign sum_o   = base_i + ofs_ext;  // wraps mod 2^PC_W
endmodule

// File: rtl/pcb_page_abs.sv
module pcb_page_abs #(
  parameter int unsigned PC_W   = 16,
  parameter int unsigned PAGE_W = 11,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [PC_W-1:0]          base_i,
  input  logic [PAGE_W-BYTE_W-1:0] page_bits_i,
  input  logic [BYTE_W-1:0]        lo_i,
  output logic [PC_W-1:0]          tgt_o
);
  localparam int unsigned KEEP_W = PC_W - PAGE_W;

  // page kept from the incremented PC
  assign tgt_o = {base_i[PC_W-1 -: KEEP_W], page_bits_i, lo_i};
endmodule

// File: rtl/pcb_ind_adder.sv
module pcb_ind_adder #(
  parameter int unsigned PC_W   = 16,
  parameter int unsigned BYTE_W = 8
) (
  input  logic [PC_W-1:0]   ptr_i,
  input  logic [BYTE_W-1:0] acc_i,
  output logic [PC_W-1:0]   sum_o
);
  localparam int unsigned PAD_W = PC_W - BYTE_W;

  assign sum_o = ptr_i + {{PAD_W{1'b0}}, acc_i};  // acc unsigned
endmodule

// File: rtl/pc_target_calc.sv
module pc_target_calc
  import pc_target_pkg::*;
#(
  parameter int unsigned AW  = PC_W,
  parameter int unsigned BW  = BYTE_W,
  parameter int unsigned PGW = PAGE_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [1:0]        mode_i,
  input  logic [AW-1:0]     next_pc_i,
  input  logic [BW-1:0]     imm_lo_i,
  input  logic [BW-1:0]     imm_hi_i,
  input  logic [PGW-BW-1:0] page_bits_i,
  input  logic [BW-1:0]     acc_i,
  input  logic [AW-1:0]     dptr_i,
  output logic [AW-1:0]     target_o,
  output logic [AW-1:0]     ret_addr_o
);
  localparam int unsigned HI_W = AW - BW;

  tgt_mode_e       mode;
  logic [AW-1:0]   rel_tgt, page_tgt, ind_tgt, long_tgt, tgt_d;
  logic [AW-1:0]   tgt_q, ret_q;

  assign mode = tgt_mode_e'(mode_i);

  pcb_rel_adder #(.PC_W(AW), .OFS_W(BW)) u_rel (
    .base_i (next_pc_i),
    .ofs_i  (imm_lo_i),
    .sum_o  (rel_tgt)
  );

  pcb_page_abs #(.PC_W(AW), .PAGE_W(PGW), .BYTE_W(BW)) u_page (
    .base_i      (next_pc_i),
    .page_bits_i (page_bits_i),
    .lo_i        (imm_lo_i),
    .tgt_o       (page_tgt)
  );

  pcb_ind_adder #(.PC_W(AW), .BYTE_W(BW)) u_ind (
    .ptr_i (dptr_i),
    .acc_i (acc_i),
    .sum_o (ind_tgt)
  );

  assign long_tgt = {imm_hi_i[HI_W-1:0], imm_lo_i};

  always_comb begin
    unique case (mode)
      TGT_REL:  tgt_d = rel_tgt;
      TGT_PAGE: tgt_d = page_tgt;
      TGT_LONG: tgt_d = long_tgt;
      TGT_IND:  tgt_d = ind_tgt;
      default:  tgt_d = rel_tgt;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tgt_q <= '0;
      ret_q <= '0;
    end else begin
      tgt_q <= tgt_d;
      ret_q <= next_pc_i;
    end
  end

  assign target_o   = tgt_q;
  assign ret_addr_o = ret_q;
endmodule

// File: rtl/pc_target_calc_chk.sv
module pc_target_calc_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic [1:0]  mode_i,
  input logic [15:0] next_pc_i,
  input logic [7:0]  imm_lo_i,
  input logic [7:0]  imm_hi_i,
  input logic [2:0]  page_bits_i,
  input logic [7:0]  acc_i,
  input logic [15:0] dptr_i,
  input logic [15:0] target_o,
  input logic [15:0] ret_addr_o
);
  logic past_ok;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) past_ok <= 1'b0;
    else         past_ok <= 1'b1;
  end

  // R7
  ret_addr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    past_ok |-> ret_addr_o == $past(next_pc_i));

  // R3
  rel_wrap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(mode_i) == 2'b00) |->
      target_o == 16'($past(next_pc_i) + {{8{$past(imm_lo_i[7])}}, $past(imm_lo_i)}));

  // R4
  page_keep_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(mode_i) == 2'b01) |->
      (target_o[15:11] == $past(next_pc_i[15:11]) && target_o[10:8] == $past(page_bits_i)
       && target_o[7:0] == $past(imm_lo_i)));

  // R5
  long_tgt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(mode_i) == 2'b10) |-> target_o == {$past(imm_hi_i), $past(imm_lo_i)});

  // R6
  ind_sum_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_ok && $past(mode_i) == 2'b11) |->
      target_o == 16'($past(dptr_i) + {8'h00, $past(acc_i)}));
endmodule

bind pc_target_calc pc_target_calc_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .mode_i      (mode_i),
  .next_pc_i   (next_pc_i),
  .imm_lo_i    (imm_lo_i),
  .imm_hi_i    (imm_hi_i),
  .page_bits_i (page_bits_i),
  .acc_i       (acc_i),
  .dptr_i      (dptr_i),
  .target_o    (target_o),
  .ret_addr_o  (ret_addr_o)
);

// File: tb/sim_pc_target_calc.sv
module sim_pc_target_calc;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'b00;
  logic [15:0] npc = '0;
  logic [7:0]  lo = '0;
  logic [7:0]  hi = '0;
  logic [2:0]  pg = '0;
  logic [7:0]  acc = '0;
  logic [15:0] dptr = '0;
  logic [15:0] tgt, ret;
  int n_cmp = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  pc_target_calc u0 (
    .clk_i(clk), .rst_ni(rst_n), .mode_i(mode), .next_pc_i(npc),
    .imm_lo_i(lo), .imm_hi_i(hi), .page_bits_i(pg), .acc_i(acc),
    .dptr_i(dptr), .target_o(tgt), .ret_addr_o(ret)
  );

  task automatic check(string req, logic [15:0] act, logic [15:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  // drive at negedge, result visible at the following negedge
  task automatic issue(logic [1:0] m, logic [15:0] p, logic [7:0] l, logic [7:0] h,
                       logic [2:0] g, logic [7:0] a, logic [15:0] d);
    @(negedge clk);
    mode = m; npc = p; lo = l; hi = h; pg = g; acc = a; dptr = d;
    @(negedge clk);
  endtask

  function automatic logic [15:0] rel_exp(logic [15:0] p, logic [7:0] o);
    int s;
    s = int'(p) + int'($signed(o));
    return 16'(s & 32'hFFFF);
  endfunction

  task automatic t_reset();
    check("R1 target", tgt, 16'h0000);
    check("R1 ret", ret, 16'h0000);
  endtask

  task automatic t_relative();
    issue(2'b00, 16'h1234, 8'h10, 8'hAA, 3'h5, 8'h33, 16'h4444);
    check("R3 fwd", tgt, rel_exp(16'h1234, 8'h10));
    check("R7 rel", ret, 16'h1234);
    issue(2'b00, 16'h1234, 8'hF0, 8'h00, 3'h0, 8'h00, 16'h0000);
    check("R3 back", tgt, 16'h1224);
    issue(2'b00, 16'hFFF0, 8'h7F, 8'h00, 3'h0, 8'h00, 16'h0000);
    check("R3 wrap up", tgt, 16'h006F);
    issue(2'b00, 16'h0005, 8'h80, 8'h00, 3'h0, 8'h00, 16'h0000);
    check("R3 wrap down", tgt, 16'hFF85);
  endtask

  task automatic t_page();
    issue(2'b01, 16'h37FF, 8'hFF, 8'h12, 3'h7, 8'h99, 16'h9999);
    check("R4 top", tgt, {5'b00110, 3'h7, 8'hFF});
    check("R7 page", ret, 16'h37FF);
    issue(2'b01, 16'h3800, 8'h00, 8'h12, 3'h0, 8'h99, 16'h9999);
    check("R4 bottom", tgt, 16'h3800);
    issue(2'b01, 16'hF9A5, 8'h5C, 8'h00, 3'h2, 8'h00, 16'h0000);
    check("R4 mid", tgt, {5'b11111, 3'h2, 8'h5C});
  endtask

  task automatic t_long();
    issue(2'b10, 16'h0100, 8'h34, 8'hAB, 3'h1, 8'h11, 16'h2222);
    check("R5 long", tgt, 16'hAB34);
    check("R7 long", ret, 16'h0100);
    issue(2'b10, 16'hFEDC, 8'h34, 8'hAB, 3'h6, 8'hEE, 16'hDDDD);
    check("R8 long ignore", tgt, 16'hAB34);
  endtask

  task automatic t_indirect();
    issue(2'b11, 16'h5555, 8'h12, 8'h34, 3'h3, 8'h20, 16'h1000);
    check("R6 ind", tgt, 16'h1020);
    check("R7 ind", ret, 16'h5555);
    issue(2'b11, 16'h0000, 8'h00, 8'h00, 3'h0, 8'hFF, 16'hFFF0);
    check("R6 wrap", tgt, 16'h00EF);
    issue(2'b11, 16'hABCD, 8'h77, 8'h88, 3'h4, 8'hFF, 16'hFFF0);
    check("R8 ind ignore", tgt, 16'h00EF);
  endtask

  task automatic t_latency();
    issue(2'b10, 16'h4000, 8'h01, 8'h02, 3'h0, 8'h00, 16'h0000);
    mode = 2'b10; hi = 8'hCC; lo = 8'hDD; npc = 16'h7777;
    #5;
    check("R2 hold tgt", tgt, 16'h0201);
    check("R2 hold ret", ret, 16'h4000);
    @(negedge clk);
    check("R2 update", tgt, 16'hCCDD);
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    npc = 16'h1111; lo = 8'h22; hi = 8'h33; acc = 8'h44; dptr = 16'h5555;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_relative();
    t_page();
    t_long();
    t_indirect();
    t_latency();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule